// File: doc/BRIEF.md
# E1 Timeslot-0 Transmit Formatter

This block produces the octet that goes into timeslot 0 of each 125 us E1 basic frame on the transmit side. Consecutive frames alternate between two formats: the alignment word, which carries a fixed seven-bit pattern, and the non-alignment word, which carries a remote alarm flag and five national spare bits. In both formats the first bit on the line comes from an input. CRC-4 remainder bits, multiframe alignment bits and E-bits are computed elsewhere and arrive on that input as plain bits.

A frame-start strobe tells the block to build the next word. The block samples its inputs once, on that strobe, and holds the resulting octet and a word-type flag until the next strobe. The same octet is loaded into a shifter. Each bit-enable pulse moves that shifter on by one position, so the octet goes out on a single serial pin, first bit first. Payload timeslots, line coding and CRC arithmetic are handled outside this block.

Top module: `e1_ts0_formatter`

## Requirements
- R1: After reset, ts0_word_o is 8'h00, ts0_nfas_o is 0 and ser_bit_o is 0. The first frame_start_i after any reset produces an alignment word.
- R2: Each frame_start_i pulse toggles the word type. ts0_nfas_o is 0 for an alignment word and 1 for a non-alignment word. Both outputs are updated at the clock edge that samples the strobe.
- R3: Line bit 2 (ts0_word_o[6]) is 0 in the alignment word and 1 in the non-alignment word.
- R4: In the alignment word, line bits 2 to 8 (ts0_word_o[6:0]) equal 7'b0011011.
- R5: Line bit 1, which is sent first, is ts0_word_o[7]. In both word types it equals intl_bit_i as sampled at the strobe.
- R6: In the non-alignment word, line bit 3 (ts0_word_o[5]) equals rai_req_i as sampled at the strobe.
- R7: In the non-alignment word, ts0_word_o[4:0] equals nat_bits_i as sampled at the strobe. nat_bits_i[4] is Sa4, placed in line bit 4, and nat_bits_i[0] is Sa8, placed in line bit 8.
- R8: Between strobes, ts0_word_o and ts0_nfas_o hold their values whatever the data inputs do.
- R9: An alignment word does not depend on rai_req_i or nat_bits_i.
- R10: After a strobe, ser_bit_o equals ts0_word_o[7]. After k bit_en_i pulses (k < 8) it equals ts0_word_o[7-k]. After 8 pulses it is 0.
- R11: When frame_start_i and bit_en_i are high in the same cycle, the strobe wins: the shifter loads the new word and does not shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe at the start of each basic frame |
| bit_en_i | input | 1 | Serial bit advance strobe |
| intl_bit_i | input | 1 | Line bit 1 for the word built at this strobe (CRC/international/multiframe/E-bit) |
| rai_req_i | input | 1 | Remote alarm request |
| nat_bits_i | input | 5 | National spare bits; [4] is Sa4, [0] is Sa8 |
| ts0_word_o | output | 8 | Current timeslot-0 octet; [7] is line bit 1 |
| ts0_nfas_o | output | 1 | 1 when the current octet is a non-alignment word |
| ser_bit_o | output | 1 | Serial output, first bit first |

## Verification
The bench sweeps all 128 combinations of the first-bit input, the alarm request and the five national bits. Each combination is applied once while an alignment word is due and once while a non-alignment word is due. The alignment frames show that alarm and national inputs never leak into the fixed pattern. The non-alignment frames separate each national bit's position from its neighbours and from the alarm bit. After every frame the bench scrambles the inputs without a strobe, shifts the full octet out bit by bit, and repeats a strobe together with a bit enable. This tells apart hold-between-strobes, bit ordering on the serial pin, and the load-over-shift priority. A mid-run reset checks that the phase restarts on an alignment word.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int NAT_W     = 5;
  localparam int OCTET_W   = NAT_W + 3;
  localparam int TAIL_W    = OCTET_W - 1;
  localparam logic [TAIL_W-1:0] FAS_TAIL = 7'b0011011;

  typedef enum logic {
    WORD_FAS  = 1'b0,
    WORD_NFAS = 1'b1
  } word_kind_e;
endpackage

// File: rtl/e1_ts0_phase.sv
module e1_ts0_phase
  import e1_ts0_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  output word_kind_e kind_o
);
  word_kind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            kind_q <= WORD_FAS;
    else if (frame_start_i) kind_q <= (kind_q == WORD_FAS) ? WORD_NFAS : WORD_FAS;
  end

  assign kind_o = kind_q;

  p_alternate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> kind_q != $past(kind_q));
  p_phase_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(kind_q));
endmodule

// File: rtl/e1_ts0_word.sv
module e1_ts0_word
  import e1_ts0_pkg::*;
#(
  parameter int NB_W = NAT_W,
  localparam int OW  = NB_W + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_start_i,
  input  word_kind_e      kind_i,
  input  logic            intl_bit_i,
  input  logic            rai_req_i,
  input  logic [NB_W-1:0] nat_bits_i,
  output logic [OW-1:0]   word_next_o,
  output logic [OW-1:0]   word_o,
  output logic            nfas_o
);
  logic [OW-1:0] word_q;
  logic          nfas_q;

  // [OW-1] is line bit 1, [0] is line bit 8
  always_comb begin
    if (kind_i == WORD_NFAS) word_next_o = {intl_bit_i, 1'b1, rai_req_i, nat_bits_i};
    else                     word_next_o = {intl_bit_i, FAS_TAIL};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      nfas_q <= 1'b0;
    end else if (frame_start_i) begin
      word_q <= word_next_o;
      nfas_q <= (kind_i == WORD_NFAS);
    end
  end

  assign word_o = word_q;
  assign nfas_o = nfas_q;

  p_fas_tail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && kind_i == WORD_FAS |=> word_o[OW-2:0] == FAS_TAIL && !nfas_o);
  p_nfas_bit2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && kind_i == WORD_NFAS |=> word_o[OW-2] && nfas_o);
  p_nfas_rai_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && kind_i == WORD_NFAS |=> word_o[OW-3] == $past(rai_req_i));
  p_nfas_nat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && kind_i == WORD_NFAS |=> word_o[NB_W-1:0] == $past(nat_bits_i));
  p_bit1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> word_o[OW-1] == $past(intl_bit_i));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(word_o) && $stable(nfas_o));
endmodule

// File: rtl/e1_ts0_serial.sv
module e1_ts0_serial #(
  parameter int OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [OW-1:0] load_word_i,
  input  logic          bit_en_i,
  output logic          ser_o
);
  logic [OW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= load_word_i;
    else if (bit_en_i) sh_q <= {sh_q[OW-2:0], 1'b0};
  end

  assign ser_o = sh_q[OW-1];

  p_load_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ser_o == $past(load_word_i[OW-1]));
  p_shift_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && bit_en_i |=> ser_o == $past(sh_q[OW-2]));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !bit_en_i |=> $stable(sh_q));
endmodule

// File: rtl/e1_ts0_formatter.sv
module e1_ts0_formatter
  import e1_ts0_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               bit_en_i,
  input  logic               intl_bit_i,
  input  logic               rai_req_i,
  input  logic [NAT_W-1:0]   nat_bits_i,
  output logic [OCTET_W-1:0] ts0_word_o,
  output logic               ts0_nfas_o,
  output logic               ser_bit_o
);
  word_kind_e         kind;
  logic [OCTET_W-1:0] word_next;

  e1_ts0_phase u_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .kind_o        (kind)
  );

  e1_ts0_word #(.NB_W(NAT_W)) u_word (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .kind_i        (kind),
    .intl_bit_i    (intl_bit_i),
    .rai_req_i     (rai_req_i),
    .nat_bits_i    (nat_bits_i),
    .word_next_o   (word_next),
    .word_o        (ts0_word_o),
    .nfas_o        (ts0_nfas_o)
  );

  e1_ts0_serial #(.OW(OCTET_W)) u_serial (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (frame_start_i),
    .load_word_i (word_next),
    .bit_en_i    (bit_en_i),
    .ser_o       (ser_bit_o)
  );

  p_type_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> ts0_nfas_o != $past(ts0_nfas_o) || $past(ts0_word_o) == '0);
  p_ser_matches_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> ser_bit_o == ts0_word_o[OCTET_W-1]);
endmodule

// File: tb/e1_ts0_formatter_tb_top.sv
`timescale 1ns/1ps
module e1_ts0_formatter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0, ben = 1'b0, ib = 1'b0, rai = 1'b0;
  logic [4:0] nat = '0;
  logic [7:0] word;
  logic       nfas, ser;
  int n_run = 0, n_fail = 0;
  logic exp_nfas = 1'b0;
  logic [7:0] exp_word = '0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_ts0_formatter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .bit_en_i(ben),
    .intl_bit_i(ib), .rai_req_i(rai), .nat_bits_i(nat),
    .ts0_word_o(word), .ts0_nfas_o(nfas), .ser_bit_o(ser));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic k, input logic b1, input logic r,
                                       input logic [4:0] n);
    return k ? {b1, 1'b1, r, n} : {b1, 7'b0011011};
  endfunction

  task automatic send_frame(input logic b1, input logic r, input logic [4:0] n,
                            input logic with_bit);
    @(negedge clk);
    ib = b1; rai = r; nat = n; fs = 1'b1; ben = with_bit;
    @(negedge clk);
    fs = 1'b0; ben = 1'b0;
    exp_word = model(exp_nfas, b1, r, n);
    check(exp_nfas ? "R3 R6 R7 nfas word" : "R4 R9 fas word", word, exp_word);
    check("R2 R3 type flag", {7'b0, nfas}, {7'b0, exp_nfas});
    check("R5 bit1", {7'b0, word[7]}, {7'b0, b1});
    check(with_bit ? "R11 load beats shift" : "R10 first serial bit", {7'b0, ser}, {7'b0, b1});
    exp_nfas = ~exp_nfas;
  endtask

  task automatic scramble_and_shift();
    @(negedge clk);
    ib = ~ib; rai = ~rai; nat = ~nat;
    repeat (2) @(negedge clk);
    check("R8 hold word", word, exp_word);
    check("R8 hold flag", {7'b0, nfas}, {7'b0, ~exp_nfas});
    for (int k = 1; k <= 8; k++) begin
      ben = 1'b1;
      @(negedge clk);
      ben = 1'b0;
      check("R10 serial bit", {7'b0, ser}, {7'b0, (k < 8) ? exp_word[7-k] : 1'b0});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", word, 8'h00);
    check("R1 reset flag", {7'b0, nfas}, 8'h00);
    check("R1 reset serial", {7'b0, ser}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", word, 8'h00);
    for (int i = 0; i < 128; i++) begin
      logic [6:0] v;
      v = 7'(i);
      send_frame(v[0], v[1], v[6:2], 1'b0);
      scramble_and_shift();
      send_frame(v[0], v[1], v[6:2], v[2]);
      scramble_and_shift();
    end
    send_frame(1'b1, 1'b1, 5'h15, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset word", word, 8'h00);
    rst_n = 1'b1;
    exp_nfas = 1'b0;
    send_frame(1'b0, 1'b1, 5'h1f, 1'b1);
    check("R1 fas first after reset", {7'b0, nfas}, 8'h00);
    send_frame(1'b1, 1'b0, 5'h0a, 1'b0);
    scramble_and_shift();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule